// File: doc/BRIEF.md
# Decimal Conditional-Sum Carry-Resolving Adder

This block turns a redundant two-word decimal value into one ordinary BCD word. It takes two operands of `NDIG` decimal digits each and returns their decimal sum as `NDIG` BCD digits plus a single decimal carry out. The first operand arrives with every digit shifted up by six. The second operand is plain BCD. With that encoding, the binary carry out of each 4-bit digit addition is the decimal carry of that digit, so no comparison against ten is needed.

Every digit position forms two candidate result digits in parallel: one that assumes no carry arrives from below and one that assumes a carry does arrive. Each candidate is corrected by six when its own 4-bit addition gives no binary carry. A logarithmic-depth parallel prefix network works out the true carry into every digit from per-digit generate and propagate flags. A 2:1 selection then keeps the right candidate. The sum and the carry out are registered once, so a result appears one clock after its operands are applied. This adder is meant to sit after a decimal partial-product reduction tree, as the last carry-resolving step of a wide decimal multiplier.

Top module: `bcdx_adder`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, that edge sets `sum_bcd` to all zeros and `cout` to 0, whatever the operands are.
- R2: The `sum_bcd` and `cout` values seen after a rising edge (with `rst` low) are computed from the operands present at that same edge. The latency is exactly one clock, and a new operand pair is accepted on every cycle.
- R3: Digit i lives in bits [4i+3:4i] of every data port, and digit 0 is the least significant. In `a_x6` each field holds the decimal digit plus 6, encoded 6..15. In `b_bcd` and `sum_bcd` each field holds the digit itself, 0..9.
- R4: For legal operands, every 4-bit field of `sum_bcd` is a valid BCD digit (0..9). Both candidate digits formed at every position are also valid BCD.
- R5: `sum_bcd` equals (A + B) mod 10^NDIG, and `cout` is 1 exactly when A + B >= 10^NDIG. No carry enters digit 0.
- R6: When every digit pair sums to 9, `sum_bcd` is all nines and `cout` is 0. If in addition a carry is produced at digit 0, that carry travels through every higher digit: all digits above digit 0 become 0 and `cout` becomes 1.
- R7: A digit pair that sums to 10 or more sends a carry to the next digit whatever its incoming carry is. A pair that sums to 8 or less absorbs any incoming carry and sends none.
- R8: The carry into each digit, as computed by the prefix network, equals the digit-serial recurrence c(i+1) = g(i) | (p(i) & c(i)) with c(0) = 0. Here g means the pair sums to 10 or more and p means it sums to exactly 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_x6 | input | 4*NDIG | First operand, each digit coded as value + 6 |
| b_bcd | input | 4*NDIG | Second operand, plain BCD digits |
| sum_bcd | output | 4*NDIG | Registered BCD sum digits |
| cout | output | 1 | Registered decimal carry out of the top digit |

## Verification
The hardest situation to reach from the ports is a carry that starts at the bottom digit and must cross every position of the prefix network. Random digit pairs almost never produce a long run of pairs summing to exactly 9. The stimulus therefore builds chains by hand: all nines plus one, all-nine pairs with no seed carry, a propagate run cut off by a pair summing to 8, and all nines plus all nines. Random vectors, applied one per cycle, cover the general mix of generate, propagate and kill digits. Each result is compared against a digit-serial integer reference.

// File: rtl/bcdx_pkg.sv
package bcdx_pkg;

    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] XS_BIAS = 4'd6;

    // one candidate digit together with its own 4-bit carry
    typedef struct packed {
        logic [DIG_W-1:0] dig;
        logic             cy;
    } cand_t;

    // both candidates of a position plus its propagate flag
    typedef struct packed {
        cand_t c0;
        cand_t c1;
        logic  prop;
    } pair_t;

    // correct a raw 5-bit digit sum into a BCD candidate
    function automatic cand_t fix_digit(input logic [DIG_W:0] raw);
        cand_t r;
        r.cy  = raw[DIG_W];
        r.dig = r.cy ? raw[DIG_W-1:0] : (raw[DIG_W-1:0] - XS_BIAS);
        return r;
    endfunction

endpackage

// File: rtl/bcdx_digit_pre.sv
module bcdx_digit_pre
    import bcdx_pkg::*;
(
    input  logic [DIG_W-1:0] a_x6_i,
    input  logic [DIG_W-1:0] b_i,
    output pair_t            pair_o
);

    logic [DIG_W:0] raw0;
    logic [DIG_W:0] raw1;

    always_comb begin
        raw0        = {1'b0, a_x6_i} + {1'b0, b_i};
        raw1        = raw0 + 5'd1;
        pair_o.c0   = fix_digit(raw0);
        pair_o.c1   = fix_digit(raw1);
        pair_o.prop = (raw0[DIG_W-1:0] == 4'hF) && !raw0[DIG_W];
    end

    // R4: both candidates are BCD when the operands are legal
    always_comb begin
        if (a_x6_i >= XS_BIAS && b_i <= 4'd9) begin
            a_r4_cand_bcd: assert (pair_o.c0.dig <= 4'd9 && pair_o.c1.dig <= 4'd9);
            // R7: a generating pair still carries when a carry also arrives
            a_r7_cand_mono: assert (!pair_o.c0.cy || pair_o.c1.cy);
        end
    end

endmodule

// File: rtl/bcdx_prefix.sv
module bcdx_prefix #(
    parameter int N = 32
) (
    input  logic [N-1:0] gen_i,
    input  logic [N-1:0] prop_i,
    output logic [N:0]   carry_o
);

    localparam int LV = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] gl [0:LV];
    logic [N-1:0] pl [0:LV-1];

    assign gl[0] = gen_i;
    assign pl[0] = prop_i;

    genvar lv, i;
    generate
        for (lv = 0; lv < LV; lv++) begin : g_lvl
            localparam int D = 1 << lv;
            for (i = 0; i < N; i++) begin : g_cell
                if (i >= D) begin : g_merge
                    assign gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-D]);
                    if (lv + 1 < LV) begin : g_pm
                        assign pl[lv+1][i] = pl[lv][i] & pl[lv][i-D];
                    end
                end else begin : g_pass
                    assign gl[lv+1][i] = gl[lv][i];
                    if (lv + 1 < LV) begin : g_pp
                        assign pl[lv+1][i] = pl[lv][i];
                    end
                end
            end
        end
    endgenerate

    assign carry_o = {gl[LV], 1'b0};

    // R8: tree carries match the digit-serial recurrence
    always_comb begin
        for (int k = 0; k < N; k++) begin
            a_r8_ripple_eq: assert (carry_o[k+1] == (gen_i[k] | (prop_i[k] & carry_o[k])));
            // R7: a generating digit always carries onward
            a_r7_gen_out: assert (!gen_i[k] || carry_o[k+1]);
            // group propagate can only hold where the digit itself propagates
            a_r8_grp_prop: assert (!pl[LV-1][k] || prop_i[k]);
        end
    end

endmodule

// File: rtl/bcdx_select.sv
module bcdx_select
    import bcdx_pkg::*;
#(
    parameter int N = 32
) (
    input  pair_t             pair_i [N],
    input  logic [N-1:0]      cin_i,
    output logic [DIG_W*N-1:0] sum_o
);

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_sel
            assign sum_o[DIG_W*i +: DIG_W] = cin_i[i] ? pair_i[i].c1.dig : pair_i[i].c0.dig;
        end
    endgenerate

endmodule

// File: rtl/bcdx_adder.sv
module bcdx_adder
    import bcdx_pkg::*;
#(
    parameter int NDIG = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [4*NDIG-1:0]     a_x6,
    input  logic [4*NDIG-1:0]     b_bcd,
    output logic [4*NDIG-1:0]     sum_bcd,
    output logic                  cout
);

    localparam int W = DIG_W * NDIG;

    pair_t            pair [NDIG];
    logic [NDIG-1:0]  gen;
    logic [NDIG-1:0]  prop;
    logic [NDIG:0]    carry;
    logic [W-1:0]     sum_d;

    genvar i;
    generate
        for (i = 0; i < NDIG; i++) begin : g_dig
            bcdx_digit_pre u_pre (
                .a_x6_i (a_x6[DIG_W*i +: DIG_W]),
                .b_i    (b_bcd[DIG_W*i +: DIG_W]),
                .pair_o (pair[i])
            );
            assign gen[i]  = pair[i].c0.cy;
            assign prop[i] = pair[i].prop;
        end
    endgenerate

    bcdx_prefix #(.N(NDIG)) u_pfx (
        .gen_i   (gen),
        .prop_i  (prop),
        .carry_o (carry)
    );

    bcdx_select #(.N(NDIG)) u_sel (
        .pair_i (pair),
        .cin_i  (carry[NDIG-1:0]),
        .sum_o  (sum_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_bcd <= '0;
            cout    <= 1'b0;
        end else begin
            sum_bcd <= sum_d;
            cout    <= carry[NDIG];
        end
    end

    function automatic logic ops_legal(input logic [W-1:0] a, input logic [W-1:0] b);
        logic ok = 1'b1;
        for (int k = 0; k < NDIG; k++)
            if (a[4*k +: 4] < 4'd6 || b[4*k +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic all_bcd(input logic [W-1:0] s);
        logic ok = 1'b1;
        for (int k = 0; k < NDIG; k++)
            if (s[4*k +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic all_nine_pairs(input logic [W-1:0] a, input logic [W-1:0] b);
        logic ok = 1'b1;
        for (int k = 0; k < NDIG; k++)
            if (({1'b0, a[4*k +: 4]} + {1'b0, b[4*k +: 4]}) != 5'd15) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic all_nines(input logic [W-1:0] s);
        logic ok = 1'b1;
        for (int k = 0; k < NDIG; k++)
            if (s[4*k +: 4] != 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // R4: registered digits are BCD after legal operands
    a_r4_out_bcd: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ops_legal($past(a_x6), $past(b_bcd))) |-> all_bcd(sum_bcd));

    // R6: a chain of nine-pairs with no seed yields nines and no carry
    a_r6_nine_chain: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && all_nine_pairs($past(a_x6), $past(b_bcd))) |-> (!cout && all_nines(sum_bcd)));

    // R7: top pair summing to ten or more forces the carry out
    a_r7_top_gen: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (({1'b0, $past(a_x6[W-1 -: 4])} + {1'b0, $past(b_bcd[W-1 -: 4])}) >= 5'd16))
        |-> cout);

endmodule

// File: tb/bcdx_adder_bench.sv
`timescale 1ns/1ps
module bcdx_adder_bench;

    localparam int ND = 32;
    localparam int W  = 4 * ND;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_x6 = '0;
    logic [W-1:0] b_bcd = '0;
    logic [W-1:0] sum_bcd;
    logic         cout;

    always #2.5 clk = ~clk;

    bcdx_adder #(.NDIG(ND)) u_bcdx_adder (
        .clk     (clk),
        .rst     (rst),
        .a_x6    (a_x6),
        .b_bcd   (b_bcd),
        .sum_bcd (sum_bcd),
        .cout    (cout)
    );

    int n_cmp = 0;
    int n_bad = 0;

    int va [ND];
    int vb [ND];

    logic [W-1:0] exp_q [$];
    logic         ecy_q [$];
    string        tag_q [$];

    task automatic compare_head();
        logic [W-1:0] es;
        logic         ec;
        string        t;
        if (exp_q.size() == 0) return;
        es = exp_q.pop_front();
        ec = ecy_q.pop_front();
        t  = tag_q.pop_front();
        n_cmp++;
        if (sum_bcd !== es || cout !== ec) begin
            n_bad++;
            $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b", t, sum_bcd, cout, es, ec);
        end
    endtask

    // at a negedge: check the previous result, then drive a new pair
    task automatic step(input string tag);
        int c = 0;
        int s;
        logic [W-1:0] es;
        @(negedge clk);
        compare_head();
        for (int k = 0; k < ND; k++) begin
            s = va[k] + vb[k] + c;
            es[4*k +: 4] = 4'(s % 10);
            c = s / 10;
            a_x6[4*k +: 4]  = 4'(va[k] + 6);
            b_bcd[4*k +: 4] = 4'(vb[k]);
        end
        exp_q.push_back(es);
        ecy_q.push_back(c[0]);
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        compare_head();
    endtask

    task automatic fill(input int x, input int y);
        for (int k = 0; k < ND; k++) begin va[k] = x; vb[k] = y; end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset clears outputs even with live operands
        a_x6  = {ND{4'hF}};
        b_bcd = {ND{4'h9}};
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (sum_bcd !== '0 || cout !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: sum=%h cout=%b expected sum=0 cout=0", sum_bcd, cout);
        end
        rst = 1'b0;

        fill(0, 0);                      step("R5 zero plus zero");
        fill(9, 0); vb[0] = 1;           step("R6 all nines plus one ripple");
        fill(4, 5);                      step("R6 nine pairs without seed");
        fill(9, 9);                      step("R7 all nines plus all nines");
        fill(4, 5); va[0] = 5; vb[0] = 7; step("R6 seeded chain through every digit");
        fill(0, 0); va[0] = 6; vb[0] = 6; va[1] = 4; vb[1] = 5; va[2] = 3; vb[2] = 5;
                                         step("R7 propagate run stopped by a pair of eight");
        fill(0, 0); va[ND-1] = 9; vb[ND-1] = 1; step("R7 top pair of ten gives carry out");
        fill(3, 2); va[0] = 9; vb[0] = 9; step("R3 digit order and excess-6 coding");
        fill(0, 0); va[ND-1] = 5; vb[ND-1] = 4; va[0] = 9; vb[0] = 9;
                                         step("R8 isolated carries at the ends");
        fill(9, 0);                      step("R2 back-to-back operand 1");
        fill(0, 9); vb[0] = 8; va[0] = 1; step("R2 back-to-back operand 2");

        for (int n = 0; n < 300; n++) begin
            for (int k = 0; k < ND; k++) begin
                va[k] = int'($urandom_range(0, 9));
                vb[k] = int'($urandom_range(0, 9));
            end
            step("R5 R4 random digits");
        end

        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < ND; k++) begin
                va[k] = int'($urandom_range(0, 9));
                vb[k] = 9 - va[k];
            end
            va[0] = int'($urandom_range(0, 9));
            step("R8 random propagate-heavy chain");
        end

        flush();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule